// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Controller

This block watches a group of general-purpose input lines, reports their current levels through a small synchronous register port, and raises interrupt requests on edges. Software picks either the rising or the falling edge for each pin. The chosen edge sets a sticky request bit, which stays set until software clears it. A per-pin enable mask and a global enable decide which requests are allowed to reach the interrupt outputs.

The outputs can be arranged in two ways. In the first, enabled pin requests are ORed with the rest of the chip's interrupt sources onto the main interrupt output. In the second, controlled by a separate-routing bit and a two-bit auxiliary select code, the pin requests leave the main output and drive a second interrupt output as a group. A system can use this second output to react to external events without first working out which of the other sources fired.

Each input passes through a synchronizer before edge detection. Register reads are combinational from `addr_i`. Writes take effect on the clock edge at which `wr_en_i` is high.

Top module: `edge_irq_gpio`

## Requirements
- R1: Address 0 reads the synchronized pin levels, with bit i standing for pin i. A pin change shows up after two clock edges. Writes to address 0 have no effect.
- R2: Address 1 holds one polarity bit per pin. A bit value of 0 selects the falling edge and a value of 1 selects the rising edge. Only the selected edge sets that pin's request, and a change of polarity is not itself treated as an edge.
- R3: The polarity bits are cleared only by `rst_ni`. A pulse on `soft_rst_i` leaves them unchanged.
- R4: Address 2 reads the per-pin request bits. A request is set whatever the state of the pin enable and the global enable.
- R5: Writing a 1 to a bit of address 2 clears that request, and writing a 0 leaves it unchanged. When a set event and a clear fall in the same cycle, the request stays set.
- R6: Address 3 holds the per-pin enables. A request reaches an output only if its enable bit is 1 and the global enable (address 4 bit 0) is 1.
- R7: When the separate-routing bit (address 4 bit 1) is 0, `irq_o` equals `other_irq_i` ORed with any enabled request, registered by one clock. `aux_irq_o` is 0 in this mode.
- R8: When the separate-routing bit is 1 and the select field (address 4 bits 3:2) is binary 10, enabled requests drive `aux_irq_o`, registered by one clock, and `irq_o` follows `other_irq_i` alone.
- R9: When the separate-routing bit is 1 and the select field is anything other than 10, `aux_irq_o` is 0 and pin requests do not appear on `irq_o`.
- R10: A pulse on `soft_rst_i` clears the request, enable and control registers.
- R11: After `rst_ni`, all registers read 0 except the level register, and both interrupt outputs are 0. The synchronizer resets to all ones, which matches the idle pulled-up level of the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| soft_rst_i | input | 1 | Synchronous soft chip reset; polarity bits are retained |
| pin_i | input | N_PINS | External input lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | N_PINS | Write data |
| rdata_o | output | N_PINS | Read data, combinational from addr_i |
| other_irq_i | input | 1 | OR of the chip's other interrupt sources |
| irq_o | output | 1 | Main interrupt output, active high |
| aux_irq_o | output | 1 | Auxiliary interrupt output, active high |

## Verification
The bench builds the block with N_PINS = 4, which is the smallest width that still holds the control field. At this width it can sweep every pin against both polarities and both transition directions. It can also sweep all sixteen control codes against both enable states and both levels of the other-sources input, checking each outcome against a value computed arithmetically from the requirements. The same-cycle set-versus-clear race and the retention of polarity across a soft reset are aimed at specific cycles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_POL   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_REQ   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd4;

  localparam logic [1:0] SEL_AUX_IRQ = 2'b10;

  typedef struct packed {
    logic [1:0] sel;
    logic       sep;
    logic       ie;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  // Reset to ones: idle pulled-up level, so no false edge after reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_req.sv
module gpio_edge_req #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] req_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic prev_q;
    logic req_q;
    logic hit;

    assign hit = pol_i[i] ? (level_i[i] & ~prev_q) : (~level_i[i] & prev_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b1;
        req_q  <= 1'b0;
      end else begin
        prev_q <= level_i[i];
        if (soft_rst_i) req_q <= 1'b0;
        else            req_q <= (req_q & ~clr_i[i]) | hit;  // set wins
      end
    end

    assign req_o[i] = req_q;
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [WIDTH-1:0] req_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic             other_irq_i,
  output logic             irq_o,
  output logic             aux_irq_o
);
  logic pin_any;
  logic main_d, aux_d;
  logic main_q, aux_q;

  assign pin_any = ctrl_i.ie & (|(req_i & en_i));
  assign main_d  = other_irq_i | (pin_any & ~ctrl_i.sep);
  assign aux_d   = pin_any & ctrl_i.sep & (ctrl_i.sel == SEL_AUX_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      main_q <= main_d;
      aux_q  <= aux_d;
    end
  end

  assign irq_o     = main_q;
  assign aux_irq_o = aux_q;
endmodule

// File: rtl/edge_irq_gpio.sv
module edge_irq_gpio
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic              other_irq_i,
  output logic              irq_o,
  output logic              aux_irq_o
);
  localparam int unsigned PAD_W = N_PINS - CTRL_W;

  logic [N_PINS-1:0] level;
  logic [N_PINS-1:0] pol_q;
  logic [N_PINS-1:0] en_q;
  logic [N_PINS-1:0] req_q;
  logic [N_PINS-1:0] clr;
  ctrl_t             ctrl_q;

  logic wr_pol, wr_req, wr_en, wr_ctrl;
  assign wr_pol  = wr_en_i && (addr_i == ADDR_POL);
  assign wr_req  = wr_en_i && (addr_i == ADDR_REQ);
  assign wr_en   = wr_en_i && (addr_i == ADDR_EN);
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign clr     = wr_req ? wdata_i : '0;

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (level)
  );

  gpio_edge_req #(.WIDTH(N_PINS)) i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .level_i   (level),
    .pol_i     (pol_q),
    .clr_i     (clr),
    .req_o     (req_q)
  );

  // Polarity: power-on reset only.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pol_q <= '0;
    else if (wr_pol) pol_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      ctrl_q <= '0;
    end else if (soft_rst_i) begin
      en_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata_i;
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_LEVEL: rdata_o = level;
      ADDR_POL:   rdata_o = pol_q;
      ADDR_REQ:   rdata_o = req_q;
      ADDR_EN:    rdata_o = en_q;
      ADDR_CTRL:  rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      default:    rdata_o = '0;
    endcase
  end

  gpio_irq_route #(.WIDTH(N_PINS)) i_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl_q),
    .req_i      (req_q),
    .en_i       (en_q),
    .other_irq_i(other_irq_i),
    .irq_o      (irq_o),
    .aux_irq_o  (aux_irq_o)
  );
endmodule

// File: rtl/edge_irq_gpio_chk.sv
module edge_irq_gpio_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              other_irq_i,
  input logic              irq_o,
  input logic              aux_irq_o,
  input logic [N_PINS-1:0] pol_q,
  input logic [N_PINS-1:0] req_q,
  input ctrl_t             ctrl_q
);
  assert_pol_retained_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_POL) |=> $stable(pol_q));

  assert_req_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && !(wr_en_i && addr_i == ADDR_REQ)) |=> ((req_q & $past(req_q)) == $past(req_q)));

  assert_other_to_main_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_irq_i |=> irq_o);

  assert_gate_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.ie && !other_irq_i) |=> !irq_o);

  assert_split_main_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.sep |=> (irq_o == $past(other_irq_i)));

  assert_aux_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_q.sep && ctrl_q.sel == SEL_AUX_IRQ) |=> !aux_irq_o);

  assert_soft_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (req_q == '0) && (ctrl_q == '0));
endmodule

bind edge_irq_gpio edge_irq_gpio_chk #(.N_PINS(N_PINS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .other_irq_i(other_irq_i),
  .irq_o      (irq_o),
  .aux_irq_o  (aux_irq_o),
  .pol_q      (pol_q),
  .req_q      (req_q),
  .ctrl_q     (ctrl_q)
);

// File: tb/test_edge_irq_gpio.sv
module test_edge_irq_gpio;
  localparam int N = 4;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [N-1:0] pin = '1;
  logic wr = 1'b0;
  logic [2:0] addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic other = 1'b0;
  logic irq, aux;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  edge_irq_gpio #(.N_PINS(N)) i_edge_irq_gpio (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .pin_i(pin),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .other_irq_i(other), .irq_o(irq), .aux_irq_o(aux)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output int d);
    @(negedge clk);
    addr = a;
    #1 d = int'(rdata);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    hard_reset();

    // R11: reset state
    rd_reg(0, v); chk("R11 level", v, int'(ALL));
    for (int a = 1; a < 8; a++) begin
      rd_reg(3'(a), v); chk("R11 reg zero", v, 0);
    end
    chk("R11 irq", int'(irq), 0);
    chk("R11 aux", int'(aux), 0);

    // R1: level per pin, writes ignored
    for (int p = 0; p < N; p++) begin
      @(negedge clk); pin = ALL & ~(N'(1) << p);
      repeat (2) @(negedge clk);
      rd_reg(0, v); chk("R1 level", v, int'(ALL & ~(N'(1) << p)));
      wr_reg(0, N'(1) << p);
      rd_reg(0, v); chk("R1 write ignored", v, int'(ALL & ~(N'(1) << p)));
      @(negedge clk); pin = ALL;
      settle();
    end
    wr_reg(2, ALL);

    // R2/R4: every pin x polarity x direction, enables and IE off
    for (int pl = 0; pl < 2; pl++) begin
      wr_reg(1, pl ? ALL : '0);
      for (int p = 0; p < N; p++) begin
        wr_reg(2, ALL);
        @(negedge clk); pin = ALL & ~(N'(1) << p);
        settle();
        rd_reg(2, v); chk("R2 R4 fall", v, pl ? 0 : (1 << p));
        wr_reg(2, ALL);
        @(negedge clk); pin = ALL;
        settle();
        rd_reg(2, v); chk("R2 R4 rise", v, pl ? (1 << p) : 0);
        wr_reg(2, ALL);
      end
    end
    // R2: polarity change alone is no edge
    wr_reg(1, '0); wr_reg(2, ALL); settle();
    rd_reg(2, v); chk("R2 pol change", v, 0);

    // R5: W1C, write 0 keeps, set beats same-cycle clear
    @(negedge clk); pin[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr = 1'b1; addr = 2; wdata = ALL;
    @(negedge clk); wr = 1'b0;
    rd_reg(2, v); chk("R5 set wins", v, 1);
    wr_reg(2, '0);
    rd_reg(2, v); chk("R5 write zero keeps", v, 1);
    wr_reg(2, 1);
    rd_reg(2, v); chk("R5 w1c", v, 0);
    // re-arm pin0 request: rise then fall
    @(negedge clk); pin[0] = 1'b1; settle();
    @(negedge clk); pin[0] = 1'b0; settle();
    rd_reg(2, v); chk("R4 rearm", v, 1);

    // R6-R9: control sweep with pin0 request pending
    for (int o = 0; o < 2; o++) begin
      for (int e = 0; e < 2; e++) begin
        for (int c = 0; c < 16; c++) begin
          int ie, sep, sel, pend, exp_irq, exp_aux;
          @(negedge clk); other = o[0];
          wr_reg(3, e ? ALL : '0);
          wr_reg(4, N'(c));
          @(negedge clk);
          ie = c & 1; sep = (c >> 1) & 1; sel = (c >> 2) & 3;
          pend = ie & e;
          exp_irq = o | (pend & (1 - sep));
          exp_aux = pend & sep & ((sel == 2) ? 1 : 0);
          if (sep == 0) begin
            chk("R6 R7 irq", int'(irq), exp_irq);
            chk("R7 aux", int'(aux), exp_aux);
          end else if (sel == 2) begin
            chk("R8 irq", int'(irq), exp_irq);
            chk("R8 aux", int'(aux), exp_aux);
          end else begin
            chk("R9 irq", int'(irq), exp_irq);
            chk("R9 aux", int'(aux), exp_aux);
          end
        end
      end
    end
    @(negedge clk); other = 1'b0;

    // R3/R10: soft reset keeps polarity, clears the rest
    wr_reg(1, 4'hA); wr_reg(3, ALL); wr_reg(4, 4'h3);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd_reg(1, v); chk("R3 pol kept", v, 'hA);
    rd_reg(2, v); chk("R10 req clear", v, 0);
    rd_reg(3, v); chk("R10 en clear", v, 0);
    rd_reg(4, v); chk("R10 ctrl clear", v, 0);
    @(negedge clk); pin[0] = 1'b1; settle();
    hard_reset();
    rd_reg(1, v); chk("R3 pol hard reset", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule